// File: doc/BRIEF.md
# Card Presence Debounce Filter

This block watches the raw card-presence pin of a contact card interface and turns its noisy edges into clean insertion and removal events. The pin is first brought into the clock domain through two flip-flops. The filtered pin level then changes only after two consecutive samples, taken at a programmed period, agree on the new level. Removal is sampled at a base period of 128, 64, 32 or 16 clocks, chosen by a 2-bit select. Insertion is sampled at three times that period, so a card must sit in the slot longer before it is reported than it must be gone before its loss is reported.

A polarity input sets which pin level means "card present". Each event sets a sticky flag that software clears by writing 1. The OR of the two flags forms the interrupt status. When auto-deactivation is enabled, a removal also produces a one-cycle request that tells the rest of the interface to stop its activity and power the card down.

Detection runs only while the engine enable is high. When the enable rises, the block adopts the current synchronized pin level as its starting state and raises no flag.

Top module: `card_detect_filter`

## Requirements
- R1: `pin_sync` equals `pin_raw` as it was two rising clock edges earlier.
- R2: For `deb_sel` values 0, 1, 2 and 3, the removal sample period P is 128, 64, 32 and 16 clocks. A stable removal sets `rem_flag` no sooner than P-4 clocks and no later than 2P+8 clocks after the pin changes.
- R3: Insertion is sampled every 3P clocks. A stable insertion sets `ins_flag` no sooner than 3P-4 clocks and no later than 6P+8 clocks after the pin changes.
- R4: With `ins_pol`=0, a low pin level means a card is present and a high-to-low change is an insertion. With `ins_pol`=1, a high level means present and a low-to-high change is an insertion.
- R5: A level change is accepted only when two consecutive samples both see it. A pulse shorter than one sample period sets no flag.
- R6: `ins_flag` and `rem_flag` stay set until a one-cycle pulse on `clr_ins` or `clr_rem`, respectively, clears them.
- R7: `cd_irq_stat` is high exactly when at least one of the two flags is set.
- R8: While `eng_en` is low, no flag is set. When `eng_en` rises, the filtered state takes the present pin level and no flag is raised. A later opposite change is then reported.
- R9: `deact_req` pulses high for exactly one cycle on each detected removal while `auto_deact_en` is 1. It stays low when `auto_deact_en` is 0.
- R10: After reset, `pin_sync`, both flags, `cd_irq_stat` and `deact_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | 1 | Asynchronous card presence pin |
| eng_en | input | 1 | Engine enable; detection runs while high |
| deb_sel | input | 2 | Debounce rate select |
| ins_pol | input | 1 | Pin level that means card present |
| auto_deact_en | input | 1 | Request deactivation on removal |
| clr_ins | input | 1 | Write-1 clear of the insert flag |
| clr_rem | input | 1 | Write-1 clear of the removal flag |
| pin_sync | output | 1 | Synchronized pin level |
| ins_flag | output | 1 | Sticky insertion event |
| rem_flag | output | 1 | Sticky removal event |
| cd_irq_stat | output | 1 | Combined card-detect interrupt status |
| deact_req | output | 1 | One-cycle deactivation request |

## Verification
A wrong filtered level shows at the ports as a missing event, or as an event of the wrong kind (insert instead of remove) after the next pin change. The error therefore becomes visible within one or two sample periods of that change. A wrong sample divider shows as a flag that rises outside its allowed latency window. The bench brackets each window from both sides, which exposes swapped insertion and removal rates. A lost pending sample shows as a glitch that is reported, or as a genuine change that is never reported.

// File: rtl/card_detect_filter.sv
module card_detect_filter #(
  parameter int BASE_DIV = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_raw,
  input  logic       eng_en,
  input  logic [1:0] deb_sel,
  input  logic       ins_pol,
  input  logic       auto_deact_en,
  input  logic       clr_ins,
  input  logic       clr_rem,
  output logic       pin_sync,
  output logic       ins_flag,
  output logic       rem_flag,
  output logic       cd_irq_stat,
  output logic       deact_req
);

  localparam int CNT_W = $clog2(BASE_DIV) + 1;

  logic             s1, s2, en_d, dlev, pend;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       ph;
  logic [CNT_W-1:0] lim;
  logic             run, start, tick_rem, tick_ins, present, tick, differ, accept;

  assign lim      = CNT_W'(BASE_DIV) >> deb_sel;
  assign run      = eng_en & en_d;
  assign start    = eng_en & ~en_d;
  assign tick_rem = run & (cnt >= lim - 1'b1);
  assign tick_ins = tick_rem & (ph == 2'd2);
  assign present  = (dlev == ins_pol);
  assign tick     = present ? tick_rem : tick_ins;
  assign differ   = (s2 != dlev);
  assign accept   = tick & differ & pend;

  assign pin_sync    = s2;
  assign cd_irq_stat = ins_flag | rem_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= pin_raw;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d <= 1'b0;
      cnt  <= '0;
      ph   <= '0;
    end else begin
      en_d <= eng_en;
      if (!run) begin
        cnt <= '0;
        ph  <= '0;
      end else if (tick_rem) begin
        cnt <= '0;
        ph  <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlev <= 1'b0;
      pend <= 1'b0;
    end else if (start) begin
      dlev <= s2;
      pend <= 1'b0;
    end else if (tick) begin
      if (!differ) pend <= 1'b0;
      else if (pend) begin
        dlev <= s2;
        pend <= 1'b0;
      end else pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_flag  <= 1'b0;
      rem_flag  <= 1'b0;
      deact_req <= 1'b0;
    end else begin
      if (accept && !present) ins_flag <= 1'b1;
      else if (clr_ins)       ins_flag <= 1'b0;
      if (accept && present)  rem_flag <= 1'b1;
      else if (clr_rem)       rem_flag <= 1'b0;
      deact_req <= accept & present & auto_deact_en;
    end
  end

  AST_INS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ins_flag && !clr_ins |=> ins_flag); // R6
  AST_REM_STICKY: assert property (@(posedge clk) disable iff (!rst_n) rem_flag && !clr_rem |=> rem_flag); // R6
  AST_DEACT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) deact_req |=> !deact_req); // R9
  AST_DEACT_WITH_REM: assert property (@(posedge clk) disable iff (!rst_n) deact_req |-> rem_flag && $past(auto_deact_en)); // R9
  AST_NO_EVENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ins_flag) || $rose(rem_flag) |-> $past(eng_en)); // R8
  AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n) !($rose(ins_flag) && $rose(rem_flag))); // R5

endmodule

// File: tb/sim_card_detect_filter.sv
module sim_card_detect_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_raw = 1'b1, eng_en = 1'b0, ins_pol = 1'b0, auto_deact_en = 1'b0;
  logic [1:0] deb_sel = 2'd3;
  logic clr_ins = 1'b0, clr_rem = 1'b0;
  logic pin_sync, ins_flag, rem_flag, cd_irq_stat, deact_req;
  int n_chk = 0, n_bad = 0, pulses = 0, cyc = 0;

  always #2.5 clk = ~clk;

  card_detect_filter u0 (.clk, .rst_n, .pin_raw, .eng_en, .deb_sel, .ins_pol,
    .auto_deact_en, .clr_ins, .clr_rem, .pin_sync, .ins_flag, .rem_flag,
    .cd_irq_stat, .deact_req);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (deact_req) pulses <= pulses + 1;
    if (cyc == 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int per(input logic [1:0] s);
    return 128 >> s;
  endfunction

  task automatic clear_all();
    clr_ins = 1'b1; clr_rem = 1'b1; step(1);
    clr_ins = 1'b0; clr_rem = 1'b0; step(1);
  endtask

  task automatic t_reset();
    step(2);
    chk(pin_sync, 1'b0, "R10 pin_sync");
    chk(ins_flag, 1'b0, "R10 ins_flag");
    chk(rem_flag, 1'b0, "R10 rem_flag");
    chk(cd_irq_stat, 1'b0, "R10 irq");
    chk(deact_req, 1'b0, "R10 deact_req");
    rst_n = 1'b1; step(2);
  endtask

  task automatic t_sync();
    pin_raw = 1'b1; step(3);
    pin_raw = 1'b0; step(1);
    chk(pin_sync, 1'b1, "R1 after one edge");
    step(1);
    chk(pin_sync, 1'b0, "R1 after two edges");
    pin_raw = 1'b1; step(2);
    chk(pin_sync, 1'b1, "R1 rise");
  endtask

  task automatic t_enable();
    ins_pol = 1'b0; pin_raw = 1'b1; step(4);
    pin_raw = 1'b0; step(8 * 3 * per(deb_sel));
    chk(ins_flag | rem_flag, 1'b0, "R8 no event while disabled");
    eng_en = 1'b1; step(8 * 3 * per(deb_sel));
    chk(ins_flag | rem_flag, 1'b0, "R8 no event at enable");
    pin_raw = 1'b1; step(2 * per(deb_sel) + 8);
    chk(rem_flag, 1'b1, "R8 adopted present then removal");
    chk(ins_flag, 1'b0, "R8 no insert");
    clear_all();
  endtask

  task automatic t_rates(input logic [1:0] s);
    int p;
    deb_sel = s; p = per(s);
    eng_en = 1'b0; step(2); eng_en = 1'b1; step(2 * 3 * p);
    pin_raw = ~ins_pol; step(3 * 3 * p); clear_all();
    pin_raw = ins_pol; step(3 * p - 4);
    chk(ins_flag, 1'b0, $sformatf("R3 insert early sel=%0d", s));
    step(3 * p + 12);
    chk(ins_flag, 1'b1, $sformatf("R3 insert late sel=%0d", s));
    chk(cd_irq_stat, 1'b1, "R7 irq on insert");
    clear_all();
    pin_raw = ~ins_pol; step(p - 6);
    chk(rem_flag, 1'b0, $sformatf("R2 remove early sel=%0d", s));
    step(p + 14);
    chk(rem_flag, 1'b1, $sformatf("R2 remove late sel=%0d", s));
    clear_all();
  endtask

  task automatic t_glitch();
    int p;
    p = per(deb_sel);
    pin_raw = ins_pol; step(6 * p + 8);
    clear_all();
    pin_raw = ~ins_pol; step(p / 2);
    pin_raw = ins_pol; step(6 * p);
    chk(rem_flag, 1'b0, "R5 glitch rejected");
    chk(ins_flag, 1'b0, "R5 no insert from glitch");
  endtask

  task automatic t_polarity();
    ins_pol = 1'b1; eng_en = 1'b0; pin_raw = 1'b0; step(4);
    eng_en = 1'b1; step(4);
    pin_raw = 1'b1; step(6 * per(deb_sel) + 8);
    chk(ins_flag, 1'b1, "R4 high means inserted");
    chk(rem_flag, 1'b0, "R4 no removal on rise");
    clear_all();
    pin_raw = 1'b0; step(2 * per(deb_sel) + 8);
    chk(rem_flag, 1'b1, "R4 low means removed");
    clear_all();
  endtask

  task automatic t_clear();
    int p;
    p = per(deb_sel);
    pin_raw = ins_pol; step(6 * p + 8);
    pin_raw = ~ins_pol; step(2 * p + 8);
    chk(ins_flag & rem_flag, 1'b1, "R6 both sticky");
    step(50);
    chk(ins_flag, 1'b1, "R6 still held");
    clr_ins = 1'b1; step(1); clr_ins = 1'b0; step(1);
    chk(ins_flag, 1'b0, "R6 ins cleared");
    chk(rem_flag, 1'b1, "R6 rem kept");
    chk(cd_irq_stat, 1'b1, "R7 irq from rem");
    clr_rem = 1'b1; step(1); clr_rem = 1'b0; step(1);
    chk(cd_irq_stat, 1'b0, "R7 irq low");
  endtask

  task automatic t_deact();
    int p, base;
    p = per(deb_sel);
    auto_deact_en = 1'b1;
    pin_raw = ins_pol; step(6 * p + 8);
    base = pulses;
    pin_raw = ~ins_pol; step(2 * p + 8);
    chk(pulses == base + 1, 1'b1, "R9 one pulse on removal");
    chk(deact_req, 1'b0, "R9 pulse ended");
    clear_all();
    auto_deact_en = 1'b0;
    pin_raw = ins_pol; step(6 * p + 8);
    base = pulses;
    pin_raw = ~ins_pol; step(2 * p + 8);
    chk(rem_flag, 1'b1, "R9 removal seen");
    chk(pulses == base, 1'b1, "R9 no pulse when disabled");
    clear_all();
  endtask

  initial begin
    t_reset();
    t_sync();
    t_enable();
    t_rates(2'd3);
    t_rates(2'd2);
    t_rates(2'd0);
    deb_sel = 2'd3;
    t_glitch();
    t_polarity();
    t_clear();
    t_deact();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule